// File: doc/BRIEF.md
# Time-Slice Two-Agent Bus Arbiter

This block decides which of two agents, a peripheral bus master or a host bridge, drives a shared bus. Exactly one grant is asserted at all times. When nobody asks for the bus, the grant stays with whichever agent had it last. The agent holding the bus signals the end of each of its transactions, and the grant can only move at such a point. The one exception is an owner that has stopped requesting, which has nothing in flight.

An 8-bit timer register gives the current owner a guaranteed slice of bus clocks. Bits 7:3 of the register set the slice, so the slice is a multiple of 8 clocks. During the slice the owner may run back-to-back transactions even when the other agent is waiting. Once the slice has run out, the next transaction end of the owner hands the bus to the other agent, provided that agent is requesting. Both agents get the same guarantee, which splits the bandwidth fairly under load. A register value of zero turns the guarantee off. In that case the arbiter re-decides at every transaction end and alternates when both agents are requesting.

A register write changes only the value held for the next handover. The slice that is already running keeps its length.

Top module: `tslice_arbiter`

## Requirements
- R1: The timer register resets to 00h. A write stores bits 7:3, and the new value appears on `cfgRdData` from the cycle after the write. Bits 2:0 are reserved: they always read 0 and writes to them are ignored (for example, a write of FFh reads back F8h and a write of 0Fh reads back 08h).
- R2: Exactly one of `grantPeriph` and `grantHost` is high in every cycle. After reset the peripheral master holds the grant.
- R3: While neither agent requests, the grant stays on the last owner.
- R4: If the owner does not request and the other agent does, the grant moves to the other agent on the next clock edge.
- R5: While the owner requests and `txnEnd` is low, the owner keeps the grant, however long its slice has been expired.
- R6: A handover takes a slice length N equal to the register value with bits 2:0 taken as zero (18h gives N = 24). Count the first cycle in which the new grant is visible as cycle 0. A `txnEnd` in cycles 0 to N-1 does not move the grant. A `txnEnd` in cycle N or later, while the other agent requests, moves the grant on the following edge.
- R7: With a slice length of zero, every `txnEnd` while the other agent requests moves the grant. With both agents requesting and `txnEnd` high in every cycle, the grant alternates every cycle.
- R8: If the slice has expired and the other agent is not requesting, the owner keeps the grant and a fresh slice of the same length starts on the next cycle.
- R9: A register write does not change the slice that is running or its reloads. The written value is first used at the next grant change.
- R10: The host bridge receives the same slice guarantee as the peripheral master.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqPeriph | input | 1 | Peripheral master requests the bus |
| reqHost | input | 1 | Host bridge requests the bus |
| txnEnd | input | 1 | The current owner is at a transaction boundary in this cycle |
| cfgWrEn | input | 1 | Write strobe for the timer register |
| cfgWrData | input | 8 | Write data for the timer register |
| cfgRdData | output | 8 | Timer register contents, with bits 2:0 always zero |
| grantPeriph | output | 1 | Bus granted to the peripheral master |
| grantHost | output | 1 | Bus granted to the host bridge |

## Verification
The bench checks the exact cycle in which an expired slice hands over. If the counter were off by one, the grant would move one cycle early or one cycle late. It also checks a slice that expires while the other agent is idle and only then sees a request. A design that did not reload the counter would hand over at once instead of after a second full slice. A register write is made in the middle of a slice: a design that applied it immediately would cut the reloaded slice short. A long transaction that runs past expiry with `txnEnd` low catches a design that pre-empts the owner. The zero setting is exercised both for alternation and for a first handover that loads a 24-clock slice.

// File: rtl/tslice_arb_pkg.sv
package tslice_arb_pkg;

  // Which agent currently holds the bus.
  typedef enum logic {
    OWN_PERIPH = 1'b0,
    OWN_HOST   = 1'b1
  } owner_e;

  // Strobes from control to the slice datapath; at most one is high.
  typedef struct packed {
    logic loadSlice;    // new grant: take the register value as the slice
    logic reloadSlice;  // expired with no contender: restart the running slice
    logic countDown;    // slice still running: decrement
  } slice_ctrl_t;

endpackage

// File: rtl/tslice_arb_dp.sv
module tslice_arb_dp
  import tslice_arb_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int RSV_BITS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  slice_ctrl_t      ctrl,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             sliceExpired
);

  localparam int SLICE_BITS = CFG_W - RSV_BITS;
  localparam logic [CFG_W-1:0] ONE = CFG_W'(1);

  logic [SLICE_BITS-1:0] cfgSlice;
  logic [CFG_W-1:0]      cfgValue;
  logic [CFG_W-1:0]      activeSlice;
  logic [CFG_W-1:0]      remaining;
  logic                  unusedRsv;

  // Reserved low bits are dropped on write and read back as zero.
  assign unusedRsv = ^cfgWrData[RSV_BITS-1:0];
  assign cfgValue  = {cfgSlice, {RSV_BITS{1'b0}}};
  assign cfgRdData = cfgValue;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgSlice <= '0;
    end else if (cfgWrEn) begin
      cfgSlice <= cfgWrData[CFG_W-1:RSV_BITS];
    end
  end

  // The slice length in force is captured only at a grant change.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeSlice <= '0;
      remaining   <= '0;
    end else if (ctrl.loadSlice) begin
      activeSlice <= cfgValue;
      remaining   <= cfgValue;
    end else if (ctrl.reloadSlice) begin
      remaining   <= activeSlice;
    end else if (ctrl.countDown) begin
      remaining   <= remaining - ONE;
    end
  end

  assign sliceExpired = (remaining == '0);

endmodule

// File: rtl/tslice_arb_ctrl.sv
module tslice_arb_ctrl
  import tslice_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqPeriph,
  input  logic        reqHost,
  input  logic        txnEnd,
  input  logic        sliceExpired,
  output slice_ctrl_t ctrl,
  output owner_e      owner
);

  owner_e ownerQ;
  logic   ownerReq;
  logic   otherReq;
  logic   handOver;

  always_comb begin
    if (ownerQ == OWN_HOST) begin
      ownerReq = reqHost;
      otherReq = reqPeriph;
    end else begin
      ownerReq = reqPeriph;
      otherReq = reqHost;
    end
  end

  // An idle owner has no transaction open; a busy one yields only at a
  // boundary after its slice has run out.
  assign handOver = otherReq && (!ownerReq || (txnEnd && sliceExpired));

  always_comb begin
    ctrl             = '0;
    ctrl.loadSlice   = handOver;
    ctrl.reloadSlice = !handOver && sliceExpired && !otherReq;
    ctrl.countDown   = !handOver && !sliceExpired;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ownerQ <= OWN_PERIPH;
    end else if (handOver) begin
      ownerQ <= (ownerQ == OWN_PERIPH) ? OWN_HOST : OWN_PERIPH;
    end
  end

  assign owner = ownerQ;

endmodule

// File: rtl/tslice_arbiter.sv
module tslice_arbiter
  import tslice_arb_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int RSV_BITS = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqPeriph,
  input  logic             reqHost,
  input  logic             txnEnd,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  output logic [CFG_W-1:0] cfgRdData,
  output logic             grantPeriph,
  output logic             grantHost
);

  slice_ctrl_t ctrl;
  owner_e      owner;
  logic        sliceExpired;

  tslice_arb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .reqPeriph    (reqPeriph),
    .reqHost      (reqHost),
    .txnEnd       (txnEnd),
    .sliceExpired (sliceExpired),
    .ctrl         (ctrl),
    .owner        (owner)
  );

  tslice_arb_dp #(
    .CFG_W    (CFG_W),
    .RSV_BITS (RSV_BITS)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgWrData    (cfgWrData),
    .ctrl         (ctrl),
    .cfgRdData    (cfgRdData),
    .sliceExpired (sliceExpired)
  );

  assign grantPeriph = (owner == OWN_PERIPH);
  assign grantHost   = (owner == OWN_HOST);

endmodule

// File: rtl/tslice_arbiter_chk.sv
module tslice_arbiter_chk #(
  parameter int CFG_W    = 8,
  parameter int RSV_BITS = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqPeriph,
  input logic             reqHost,
  input logic             txnEnd,
  input logic             cfgWrEn,
  input logic [CFG_W-1:0] cfgWrData,
  input logic [CFG_W-1:0] cfgRdData,
  input logic             grantPeriph,
  input logic             grantHost
);

  // R2: exactly one grant
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rstN)
    $countones({grantPeriph, grantHost}) == 1);

  // R1: reserved bits read zero
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdData[RSV_BITS-1:0] == '0);

  // R1: write lands the next cycle with the reserved bits masked
  p_wr_lands_r1: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgRdData[CFG_W-1:RSV_BITS] == $past(cfgWrData[CFG_W-1:RSV_BITS]));

  // R3: parked grant
  p_park_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!reqPeriph && !reqHost) |=> $stable(grantPeriph));

  // R4: idle owner hands over to a requester
  p_idle_periph_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grantPeriph && !reqPeriph && reqHost) |=> grantHost);
  p_idle_host_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grantHost && !reqHost && reqPeriph) |=> grantPeriph);

  // R5: an open transaction is never cut off
  p_no_cut_periph_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grantPeriph && reqPeriph && !txnEnd) |=> grantPeriph);
  p_no_cut_host_r5: assert property (@(posedge clk) disable iff (!rstN)
    (grantHost && reqHost && !txnEnd) |=> grantHost);

endmodule

bind tslice_arbiter tslice_arbiter_chk #(
  .CFG_W    (CFG_W),
  .RSV_BITS (RSV_BITS)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqPeriph   (reqPeriph),
  .reqHost     (reqHost),
  .txnEnd      (txnEnd),
  .cfgWrEn     (cfgWrEn),
  .cfgWrData   (cfgWrData),
  .cfgRdData   (cfgRdData),
  .grantPeriph (grantPeriph),
  .grantHost   (grantHost)
);

// File: tb/tslice_arbiter_bench.sv
`timescale 1ns/1ps
module tslice_arbiter_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqPeriph = 1'b0;
  logic       reqHost = 1'b0;
  logic       txnEnd = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = 8'h00;
  logic [7:0] cfgRdData;
  logic       grantPeriph;
  logic       grantHost;

  typedef struct {
    logic       expGp;
    logic [7:0] expRd;
    string      tag;
  } item_t;

  item_t      scoreQ[$];
  int         total = 0;
  int         bad = 0;
  logic [7:0] expRd = 8'h00;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tslice_arbiter u_tslice_arbiter (
    .clk         (clk),
    .rstN        (rstN),
    .reqPeriph   (reqPeriph),
    .reqHost     (reqHost),
    .txnEnd      (txnEnd),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .grantPeriph (grantPeriph),
    .grantHost   (grantHost)
  );

  // Driver: one bus cycle of stimulus, then the expected state after the edge.
  task automatic step(input logic p, input logic h, input logic t,
                      input logic we, input logic [7:0] wd,
                      input logic expGp, input string tag);
    item_t it;
    @(negedge clk);
    reqPeriph = p; reqHost = h; txnEnd = t; cfgWrEn = we; cfgWrData = wd;
    @(posedge clk);
    #1;
    if (we) expRd = {wd[7:3], 3'b000};
    it.expGp = expGp; it.expRd = expRd; it.tag = tag;
    scoreQ.push_back(it);
  endtask

  task automatic repeatStep(input int n, input logic p, input logic h,
                            input logic t, input logic expGp, input string tag);
    for (int i = 0; i < n; i++) step(p, h, t, 1'b0, 8'h00, expGp, tag);
  endtask

  // Monitor: compare at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (scoreQ.size() != 0) begin
      item_t it;
      it = scoreQ.pop_front();
      total++;
      if (grantPeriph !== it.expGp || grantHost !== !it.expGp) begin
        bad++;
        $display("FAIL %s grant actual=%b%b expected=%b%b", it.tag,
                 grantPeriph, grantHost, it.expGp, !it.expGp);
      end
      total++;
      if (cfgRdData !== it.expRd) begin
        bad++;
        $display("FAIL %s cfgRdData actual=%h expected=%h", it.tag,
                 cfgRdData, it.expRd);
      end
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 R2: reset state, peripheral holds the grant
    step(0, 0, 0, 0, 8'h00, 1'b1, "R1/R2 reset");
    // R3: parked on peripheral
    repeatStep(3, 0, 0, 1, 1'b1, "R3 park periph");
    // R1: reserved bits are dropped
    step(0, 0, 0, 1, 8'hFF, 1'b1, "R1 write FF");
    step(0, 0, 0, 1, 8'h0F, 1'b1, "R1 write 0F");
    // R4: idle owner releases; slice N=8 loaded for the host
    step(0, 1, 0, 0, 8'h00, 1'b0, "R4 idle release");
    // R10 R6: host keeps the bus through boundaries in cycles 0..7
    repeatStep(8, 1, 1, 1, 1'b0, "R10 host slice held");
    step(1, 1, 1, 0, 8'h00, 1'b1, "R6 hand over at cycle N");
    // R5: no boundary, no handover long past expiry
    repeatStep(12, 1, 1, 0, 1'b1, "R5 no cut");
    step(1, 1, 1, 0, 8'h00, 1'b0, "R5 boundary hands over");
    // R9 R8: write 00 during the host slice; reload still uses 8
    step(0, 1, 1, 1, 8'h00, 1'b0, "R9 write mid slice");
    repeatStep(8, 0, 1, 1, 1'b0, "R8 other idle");
    repeatStep(8, 1, 1, 1, 1'b0, "R8 fresh slice");
    step(1, 1, 1, 0, 8'h00, 1'b1, "R8 reloaded slice ends");
    // R7: zero setting is now active, alternation
    step(1, 1, 1, 0, 8'h00, 1'b0, "R7 alternate");
    step(1, 1, 1, 0, 8'h00, 1'b1, "R7 alternate");
    step(1, 1, 1, 0, 8'h00, 1'b0, "R7 alternate");
    step(1, 1, 1, 0, 8'h00, 1'b1, "R7 alternate");
    repeatStep(2, 1, 1, 0, 1'b1, "R7 no boundary");
    // R9 R6: write 18h, applied only at the next handover (N=24)
    step(1, 1, 0, 1, 8'h18, 1'b1, "R9 write 18");
    step(1, 1, 1, 0, 8'h00, 1'b0, "R9 zero slice still active");
    repeatStep(24, 1, 1, 1, 1'b0, "R6 24-clock slice held");
    step(1, 1, 1, 0, 8'h00, 1'b1, "R6 24-clock slice ends");
    // R4 R3: move to host, then park there
    step(0, 1, 0, 0, 8'h00, 1'b0, "R4 idle release");
    repeatStep(3, 0, 0, 0, 1'b0, "R3 park host");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule